// File: doc/BRIEF.md
# SPI Flash Passthrough Proxy

This block relays single-lane SPI traffic from an upstream master to a downstream serial flash. It can also inspect, block, answer or rewrite that traffic on the way. The upstream link is modelled bit-synchronously to the block clock: while `upCsN` is low, each clock carries one bit on `upMosi`, most significant bit first. The first eight bits of a transaction form its opcode. The opcode is looked up in a table of programmable command slots, and the matched slot says what happens to the rest of the transaction.

Everything sent downstream trails the upstream bits by exactly eight clocks. The transaction's handling is therefore settled before its first bit leaves the block, so a blocked command never pulls the downstream chip select low. A forwarded command can have chosen address bits replaced in flight. A command held by a hardware slot can be answered locally with a programmed reply byte. Data returning from the flash reaches the upstream side through a two-byte pipeline. The block also drives the enable of a downstream bus multiplexer, which bypasses an internal SPI host while the proxy owns the bus. This bypass exists only when that host has a single chip-select line.

Top module: `spi_pt_proxy`

## Requirements
- R1: `ptEnable` is high exactly when `proxyOn` is 1 and `NUM_HOST_CS` is 1. While it is low, every incoming bit is discarded: `dnCsN` stays 1, `dnMosi` stays 0 and `upMiso` stays 1.
- R2: While the proxy is on, a transaction whose opcode matches no valid slot is reproduced on `dnCsN`/`dnMosi` unchanged, exactly 8 clocks after the upstream bits.
- R3: When several valid slots (`slotValid[i]`=1, opcode in `slotOpcode[8i+7:8i]`) hold the same opcode, the slot with the lowest index decides.
- R4: A matched slot with action code 1 (block) keeps `dnCsN` high for the whole transaction, and `upMiso` returns 1 for every bit.
- R5: A matched slot with action code 2 (answer locally) and index at least `HW_FIRST_SLOT` keeps `dnCsN` high. From bit 8 onward, `upMiso` returns `replyByte` MSB first, repeating every 8 bits.
- R6: Action code 2 is ignored, and the command is forwarded as in R2, when the slot index is below `HW_FIRST_SLOT` or the opcode is 0x06 or 0x04. Action codes 0 and 3 forward.
- R7: The address length of a matched slot comes from its 2-bit mode in `slotAddrMode[2i+1:2i]`: 0 = none, 1 = 3 bytes, 2 = 4 bytes, 3 = 4 bytes if `fourByteEn` is set and 3 bytes otherwise.
- R8: For a forwarded command whose slot has `slotSwapEn` set, the address bit with weight m (m=0 is the last address bit sent) goes downstream as `swapData[m]` where `swapMask[m]` is 1, and unchanged otherwise. Opcode and payload bits are never altered.
- R9: During a forwarded transaction, `upMiso` shows `dnMiso` delayed by 16 clocks (two bytes) from bit 8 onward. It is 1 during the opcode bits and while `upCsN` is high.
- R10: All per-transaction state clears when `upCsN` rises. The next transaction is decoded afresh even with a one-clock gap. A transaction shorter than 8 bits is forwarded unchanged. After reset, `dnCsN`=1, `dnMosi`=0 and `upMiso`=1.
- R11: With `NUM_HOST_CS` other than 1, the block never drives the downstream bus: `ptEnable`=0, `dnCsN`=1 and `upMiso`=1, whatever `proxyOn` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one SPI bit per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| proxyOn | input | 1 | 1 = passthrough mode, 0 = disabled mode |
| fourByteEn | input | 1 | Current 4-byte addressing state |
| slotValid | input | NUM_SLOTS | Per-slot enable |
| slotOpcode | input | 8*NUM_SLOTS | Per-slot opcode, slot i at bits 8i+7:8i |
| slotAction | input | 2*NUM_SLOTS | Per-slot action: 0 forward, 1 block, 2 answer locally |
| slotAddrMode | input | 2*NUM_SLOTS | Per-slot address mode (see R7) |
| slotSwapEn | input | NUM_SLOTS | Per-slot address rewrite enable |
| swapMask | input | 32 | Address bits to replace |
| swapData | input | 32 | Replacement address bits |
| replyByte | input | 8 | Local answer for intercepted commands |
| upCsN | input | 1 | Upstream chip select, active low |
| upMosi | input | 1 | Upstream serial data in |
| upMiso | output | 1 | Upstream serial data out |
| dnCsN | output | 1 | Downstream chip select, active low |
| dnMosi | output | 1 | Downstream serial data out |
| dnMiso | input | 1 | Downstream serial data in |
| ptEnable | output | 1 | Bypass-mux enable, active high |

## Verification
The bench sends transactions separated by a single idle clock. A design that tied a transaction's handling to live state, rather than to its delayed first bit, would apply the previous command's block or rewrite to the next one. The address rewrite is tested at both address lengths and with the configured length switched by `fourByteEn`. A wrong bit mapping, or a rewrite that spills into opcode or payload, shows up as a mismatch on `dnMosi`. Intercept requests on a low slot and on the write-enable and write-disable opcodes must still reach the flash, and a duplicate opcode in a later slot must lose. A design that misapplied either rule would raise `dnCsN` or return the reply byte. A second instance built with two host chip selects must never touch the downstream bus.

// File: rtl/spi_pt_pkg.sv
`timescale 1ns/100ps
package spi_pt_pkg;

  localparam int OPC_BITS = 8;
  localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
  localparam logic [7:0] OP_WR_DISABLE = 8'h04;

  typedef enum logic [1:0] {
    ACT_FWD       = 2'd0,
    ACT_BLOCK     = 2'd1,
    ACT_INTERCEPT = 2'd2,
    ACT_SPARE     = 2'd3
  } slotAct_e;

  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_3B   = 2'd1,
    AM_4B   = 2'd2,
    AM_CFG  = 2'd3
  } addrMode_e;

  // handling chosen for one transaction
  typedef struct packed {
    logic       fwd;
    logic       intercept;
    logic       swapEn;
    logic [2:0] addrBytes;
  } txDec_t;

  localparam txDec_t DEC_IDLE = '{fwd: 1'b1, intercept: 1'b0, swapEn: 1'b0, addrBytes: 3'd0};

  // strobes from control to datapath
  typedef struct packed {
    logic bitValid;
    logic sof;
    logic decided;
  } ptStrobe_t;

endpackage

// File: rtl/spi_pt_slot_match.sv
`timescale 1ns/100ps
module spi_pt_slot_match #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input  logic [7:0]             opcode,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  input  logic [8*NUM_SLOTS-1:0] slotOpcode,
  output logic                   hit,
  output logic [IDX_W-1:0]       hitIdx
);

  logic [NUM_SLOTS-1:0] hitVec;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign hitVec[g] = slotValid[g] && (slotOpcode[g*8 +: 8] == opcode);
  end

  // lowest index wins
  always_comb begin
    hit    = |hitVec;
    hitIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/spi_pt_ctrl.sv
`timescale 1ns/100ps
module spi_pt_ctrl
  import spi_pt_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int HW_FIRST_SLOT = 4,
  parameter int CNT_W         = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   upCsN,
  input  logic                   upMosi,
  input  logic                   fourByteEn,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  input  logic [8*NUM_SLOTS-1:0] slotOpcode,
  input  logic [2*NUM_SLOTS-1:0] slotAction,
  input  logic [2*NUM_SLOTS-1:0] slotAddrMode,
  input  logic [NUM_SLOTS-1:0]   slotSwapEn,
  output ptStrobe_t              strobe,
  output txDec_t                 curDec,
  output logic [CNT_W-1:0]       bitCount
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LAST_OPC = CNT_W'(OPC_BITS - 1);

  logic [OPC_BITS-2:0] opShift;
  logic [7:0]          opcodeFull;
  logic                hit;
  logic [IDX_W-1:0]    hitIdx;
  logic                decided;
  txDec_t              nextDec;
  slotAct_e            act;
  addrMode_e           amode;

  assign opcodeFull = {opShift, upMosi};

  spi_pt_slot_match #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_match (
    .opcode    (opcodeFull),
    .slotValid (slotValid),
    .slotOpcode(slotOpcode),
    .hit       (hit),
    .hitIdx    (hitIdx)
  );

  always_comb begin
    act     = slotAct_e'(slotAction[hitIdx*2 +: 2]);
    amode   = addrMode_e'(slotAddrMode[hitIdx*2 +: 2]);
    nextDec = DEC_IDLE;
    if (hit) begin
      unique case (amode)
        AM_NONE: nextDec.addrBytes = 3'd0;
        AM_3B:   nextDec.addrBytes = 3'd3;
        AM_4B:   nextDec.addrBytes = 3'd4;
        default: nextDec.addrBytes = fourByteEn ? 3'd4 : 3'd3;
      endcase
      unique case (act)
        ACT_BLOCK: nextDec.fwd = 1'b0;
        ACT_INTERCEPT: begin
          if (int'(hitIdx) >= HW_FIRST_SLOT &&
              opcodeFull != OP_WR_ENABLE && opcodeFull != OP_WR_DISABLE) begin
            nextDec.fwd       = 1'b0;
            nextDec.intercept = 1'b1;
          end
        end
        default: ;
      endcase
      nextDec.swapEn = slotSwapEn[hitIdx] & nextDec.fwd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      opShift  <= '0;
      decided  <= 1'b0;
      curDec   <= DEC_IDLE;
    end else if (upCsN) begin
      bitCount <= '0;
      opShift  <= '0;
      decided  <= 1'b0;
      curDec   <= DEC_IDLE;
    end else begin
      if (bitCount != CNT_MAX) bitCount <= bitCount + 1'b1;
      if (bitCount < LAST_OPC) opShift <= {opShift[OPC_BITS-3:0], upMosi};
      if (bitCount == LAST_OPC) begin
        curDec  <= nextDec;
        decided <= 1'b1;
      end
    end
  end

  assign strobe.bitValid = !upCsN;
  assign strobe.sof      = !upCsN && (bitCount == '0);
  assign strobe.decided  = decided;

endmodule

// File: rtl/spi_pt_datapath.sv
`timescale 1ns/100ps
module spi_pt_datapath
  import spi_pt_pkg::*;
#(
  parameter int PIPE_BYTES = 2,
  parameter int CNT_W      = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ptOn,
  input  ptStrobe_t   strobe,
  input  logic        upMosi,
  input  txDec_t      curDec,
  input  logic [2:0]  bitLow,
  input  logic        dnMiso,
  input  logic [31:0] swapMask,
  input  logic [31:0] swapData,
  input  logic [7:0]  replyByte,
  output logic        dnCsN,
  output logic        dnMosi,
  output logic        upMiso
);

  localparam int DLY       = OPC_BITS;
  localparam int PIPE_BITS = PIPE_BYTES * 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef struct packed {
    logic v;
    logic s;
    logic d;
  } dlEnt_t;

  dlEnt_t [DLY-1:0]       dl;
  dlEnt_t                 inEnt;
  dlEnt_t                 exitE;
  txDec_t                 outDec;
  txDec_t                 effDec;
  logic [CNT_W-1:0]       outCnt;
  logic [CNT_W-1:0]       effCnt;
  logic [CNT_W-1:0]       addrBits;
  logic [4:0]             swapIdx;
  logic                   inAddr;
  logic                   mosiOut;
  logic                   dnActive;
  logic [PIPE_BITS-1:0]   misoPipe;

  assign inEnt = '{v: strobe.bitValid, s: strobe.sof, d: upMosi & strobe.bitValid};
  assign exitE = dl[DLY-1];

  // handling of the exiting bit: a start bit picks up the fresh decision
  assign effDec = (exitE.v && exitE.s) ? curDec : outDec;
  assign effCnt = exitE.s ? '0 : outCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dl       <= '0;
      outDec   <= DEC_IDLE;
      outCnt   <= '0;
      misoPipe <= '1;
    end else begin
      dl       <= {dl[DLY-2:0], inEnt};
      misoPipe <= {misoPipe[PIPE_BITS-2:0], dnMiso};
      if (exitE.v) begin
        outDec <= effDec;
        if (effCnt != CNT_MAX) outCnt <= effCnt + 1'b1;
      end
    end
  end

  // address rewrite
  always_comb begin
    addrBits = CNT_W'(effDec.addrBytes) << 3;
    inAddr   = effDec.swapEn && (effCnt >= CNT_W'(OPC_BITS)) &&
               (effCnt < addrBits + CNT_W'(OPC_BITS));
    swapIdx  = 5'(addrBits + CNT_W'(OPC_BITS - 1) - effCnt);
    mosiOut  = (inAddr && swapMask[swapIdx]) ? swapData[swapIdx] : exitE.d;
  end

  assign dnActive = ptOn && exitE.v && effDec.fwd;
  assign dnCsN    = !dnActive;
  assign dnMosi   = dnActive & mosiOut;

  always_comb begin
    if (!ptOn || !strobe.bitValid || !strobe.decided) upMiso = 1'b1;
    else if (curDec.intercept)                        upMiso = replyByte[3'd7 - bitLow];
    else if (!curDec.fwd)                             upMiso = 1'b1;
    else                                              upMiso = misoPipe[PIPE_BITS-1];
  end

endmodule

// File: rtl/spi_pt_proxy.sv
`timescale 1ns/100ps
module spi_pt_proxy
  import spi_pt_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int HW_FIRST_SLOT = 4,
  parameter int NUM_HOST_CS   = 1,
  parameter int PIPE_BYTES    = 2,
  parameter int CNT_W         = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   proxyOn,
  input  logic                   fourByteEn,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  input  logic [8*NUM_SLOTS-1:0] slotOpcode,
  input  logic [2*NUM_SLOTS-1:0] slotAction,
  input  logic [2*NUM_SLOTS-1:0] slotAddrMode,
  input  logic [NUM_SLOTS-1:0]   slotSwapEn,
  input  logic [31:0]            swapMask,
  input  logic [31:0]            swapData,
  input  logic [7:0]             replyByte,
  input  logic                   upCsN,
  input  logic                   upMosi,
  output logic                   upMiso,
  output logic                   dnCsN,
  output logic                   dnMosi,
  input  logic                   dnMiso,
  output logic                   ptEnable
);

  ptStrobe_t        strobe;
  txDec_t           curDec;
  logic [CNT_W-1:0] bitCount;

  if (NUM_HOST_CS == 1) begin : g_bypass
    assign ptEnable = proxyOn;
  end else begin : g_nobypass
    assign ptEnable = 1'b0;
  end

  spi_pt_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .HW_FIRST_SLOT(HW_FIRST_SLOT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk, .rstN, .upCsN, .upMosi, .fourByteEn,
    .slotValid, .slotOpcode, .slotAction, .slotAddrMode, .slotSwapEn,
    .strobe, .curDec, .bitCount
  );

  spi_pt_datapath #(.PIPE_BYTES(PIPE_BYTES), .CNT_W(CNT_W)) u_dp (
    .clk, .rstN,
    .ptOn     (ptEnable),
    .strobe, .upMosi, .curDec,
    .bitLow   (bitCount[2:0]),
    .dnMiso, .swapMask, .swapData, .replyByte,
    .dnCsN, .dnMosi, .upMiso
  );

endmodule

// File: rtl/spi_pt_proxy_chk.sv
`timescale 1ns/100ps
module spi_pt_proxy_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             upCsN,
  input logic             upMiso,
  input logic             dnCsN,
  input logic             dnMosi,
  input logic             ptEnable,
  input logic [CNT_W-1:0] bitCount
);

  logic [3:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 4'hF) sinceRst <= sinceRst + 1'b1;
  end

  // R1: without the bypass the downstream bus stays idle
  a_r1_dn_idle_off: assert property (@(posedge clk) disable iff (!rstN)
    !ptEnable |-> (dnCsN && !dnMosi));

  // R4: data line is quiet whenever the flash is deselected
  a_r4_mosi_quiet: assert property (@(posedge clk) disable iff (!rstN)
    dnCsN |-> !dnMosi);

  // R9: upstream data out idles high between transactions
  a_r9_miso_idle: assert property (@(posedge clk) disable iff (!rstN)
    upCsN |-> upMiso);

  // R10: bit position restarts after the upstream select is released
  a_r10_count_clear: assert property (@(posedge clk) disable iff (!rstN)
    upCsN |=> (bitCount == '0));

  // R2: a selected downstream bit stems from a selected upstream bit 8 clocks earlier
  a_r2_cs_origin: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst >= 4'd9) && !dnCsN) |-> !$past(upCsN, 8));

endmodule

bind spi_pt_proxy spi_pt_proxy_chk u_chk (.*);

// File: tb/test_spi_pt_proxy.sv
`timescale 1ns/100ps
module test_spi_pt_proxy;

  localparam int MAXC = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic proxyOn = 1'b1;
  logic fourByteEn = 1'b0;
  logic [7:0]  slotValidV;
  logic [63:0] slotOpcodeV;
  logic [15:0] slotActionV;
  logic [15:0] slotAddrModeV;
  logic [7:0]  slotSwapEnV;
  logic [31:0] swapMaskV;
  logic [31:0] swapDataV;
  logic [7:0]  replyV;
  logic upCsN = 1'b1;
  logic upMosi = 1'b0;
  logic dnMiso = 1'b1;
  logic upMiso, dnCsN, dnMosi, ptEnable;
  logic upMiso2, dnCsN2, dnMosi2, ptEnable2;

  always #2.5 clk = ~clk;

  spi_pt_proxy i_spi_pt_proxy (
    .clk, .rstN, .proxyOn, .fourByteEn,
    .slotValid(slotValidV), .slotOpcode(slotOpcodeV), .slotAction(slotActionV),
    .slotAddrMode(slotAddrModeV), .slotSwapEn(slotSwapEnV),
    .swapMask(swapMaskV), .swapData(swapDataV), .replyByte(replyV),
    .upCsN, .upMosi, .upMiso, .dnCsN, .dnMosi, .dnMiso, .ptEnable
  );

  spi_pt_proxy #(.NUM_HOST_CS(2)) i_spi_pt_proxy_mcs (
    .clk, .rstN, .proxyOn, .fourByteEn,
    .slotValid(slotValidV), .slotOpcode(slotOpcodeV), .slotAction(slotActionV),
    .slotAddrMode(slotAddrModeV), .slotSwapEn(slotSwapEnV),
    .swapMask(swapMaskV), .swapData(swapDataV), .replyByte(replyV),
    .upCsN, .upMosi, .upMiso(upMiso2), .dnCsN(dnCsN2), .dnMosi(dnMosi2),
    .dnMiso, .ptEnable(ptEnable2)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int nTx = 1;
  bit finished = 0;
  string curReq = "R10";
  logic [15:0] lfsr = 16'hACE1;

  bit hV [MAXC];
  bit hD [MAXC];
  bit hM [MAXC];
  int hTx [MAXC];
  int hIdx [MAXC];
  bit tFwd [256];
  bit tInt [256];
  bit tSwp [256];
  int tAb [256];

  task automatic chk(input logic got, input logic exp, input string what);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s got %b expected %b at cycle %0d", curReq, what, got, exp, cyc);
    end
  endtask

  // reference decision from the requirements
  task automatic decide(input logic [7:0] opc, input int tx);
    tFwd[tx] = 1; tInt[tx] = 0; tSwp[tx] = 0; tAb[tx] = 0;
    for (int s = 0; s < 8; s++) begin
      if (slotValidV[s] && slotOpcodeV[s*8 +: 8] == opc) begin
        case (slotAddrModeV[s*2 +: 2])
          2'd0: tAb[tx] = 0;
          2'd1: tAb[tx] = 3;
          2'd2: tAb[tx] = 4;
          default: tAb[tx] = fourByteEn ? 4 : 3;
        endcase
        if (slotActionV[s*2 +: 2] == 2'd1) tFwd[tx] = 0;
        if (slotActionV[s*2 +: 2] == 2'd2 && s >= 4 && opc != 8'h06 && opc != 8'h04) begin
          tFwd[tx] = 0; tInt[tx] = 1;
        end
        tSwp[tx] = slotSwapEnV[s] && tFwd[tx];
        break;
      end
    end
  endtask

  task automatic step(input bit csN, input bit mosi, input int tx, input int idx);
    bit eCs, eMosi, eMiso;
    int p, m, ab;
    @(negedge clk);
    upCsN = csN;
    upMosi = mosi;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dnMiso = lfsr[0];
    hV[cyc] = !csN; hD[cyc] = mosi; hM[cyc] = lfsr[0]; hTx[cyc] = tx; hIdx[cyc] = idx;
    #1;
    p = cyc - 8;
    eCs = 1; eMosi = 0;
    if (proxyOn && p >= 0 && hV[p] && tFwd[hTx[p]]) begin
      eCs = 0;
      eMosi = hD[p];
      ab = tAb[hTx[p]] * 8;
      if (tSwp[hTx[p]] && hIdx[p] >= 8 && hIdx[p] < 8 + ab) begin
        m = ab + 7 - hIdx[p];
        if (swapMaskV[m]) eMosi = swapDataV[m];
      end
    end
    eMiso = 1;
    if (proxyOn && !csN && idx >= 8) begin
      if (tInt[tx]) eMiso = replyV[7 - (idx % 8)];
      else if (tFwd[tx]) eMiso = (cyc >= 16) ? hM[cyc-16] : 1'b1;
    end
    chk(ptEnable, proxyOn, "ptEnable");
    chk(dnCsN, eCs, "dnCsN");
    chk(dnMosi, eMosi, "dnMosi");
    chk(upMiso, eMiso, "upMiso");
    // R11: two-select variant never owns the bus
    chk(ptEnable2, 1'b0, "R11 ptEnable");
    chk(dnCsN2, 1'b1, "R11 dnCsN");
    chk(dnMosi2, 1'b0, "R11 dnMosi");
    chk(upMiso2, 1'b1, "R11 upMiso");
    cyc++;
  endtask

  task automatic sendTx(input int nbits, input logic [63:0] data, input int gap);
    int tx;
    tx = nTx;
    nTx++;
    tFwd[tx] = 1; tInt[tx] = 0; tSwp[tx] = 0; tAb[tx] = 0;
    if (nbits >= 8) decide(data[63:56], tx);
    for (int i = 0; i < nbits; i++) step(1'b0, data[63-i], tx, i);
    for (int g = 0; g < gap; g++) step(1'b1, 1'b0, 0, 0);
  endtask

  initial begin
    // slot 7 .. slot 0
    slotValidV    = 8'hFF;
    slotOpcodeV   = {8'h03, 8'h04, 8'h06, 8'h05, 8'h9F, 8'h20, 8'h0B, 8'h03};
    slotActionV   = {2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd1, 2'd0, 2'd0};
    slotAddrModeV = {2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3};
    slotSwapEnV   = 8'b0000_0111;
    swapMaskV     = 32'hF0FF_00F0;
    swapDataV     = 32'h50A5_0030;
    replyV        = 8'h5A;
    tFwd[0] = 1; tInt[0] = 0; tSwp[0] = 0; tAb[0] = 0;

    repeat (3) @(negedge clk);
    #1;
    curReq = "R10 reset";
    chk(dnCsN, 1'b1, "dnCsN");
    chk(dnMosi, 1'b0, "dnMosi");
    chk(upMiso, 1'b1, "upMiso");
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 0, 0);

    curReq = "R2 unmatched";
    sendTx(40, 64'h77C3_1E5A_9600_0000, 20);
    sendTx(24, 64'hA188_FF00_0000_0000, 20);

    curReq = "R8 R7 R3 3-byte rewrite";
    sendTx(64, 64'h0312_3456_DEAD_BEEF, 20);
    fourByteEn = 1'b1;
    curReq = "R8 R7 4-byte by config";
    sendTx(64, 64'h03FE_DCBA_9876_5432, 20);
    fourByteEn = 1'b0;
    curReq = "R8 R7 fixed 4-byte";
    sendTx(64, 64'h0B01_2345_67AA_5511, 20);

    curReq = "R4 block";
    sendTx(40, 64'h2011_2233_4400_0000, 20);

    curReq = "R5 intercept";
    sendTx(40, 64'h05FF_FFFF_FF00_0000, 20);

    curReq = "R6 low slot intercept";
    sendTx(32, 64'h9F00_0000_0000_0000, 20);
    curReq = "R6 write enable";
    sendTx(8, 64'h0600_0000_0000_0000, 20);
    curReq = "R6 write disable";
    sendTx(16, 64'h04C0_0000_0000_0000, 20);

    curReq = "R9 read return";
    sendTx(64, 64'h0300_0010_0000_0000, 20);

    curReq = "R10 back-to-back";
    sendTx(32, 64'h2000_1122_0000_0000, 1);
    sendTx(5, 64'hF800_0000_0000_0000, 1);
    sendTx(40, 64'h0B80_0000_01C3_0000, 1);
    sendTx(24, 64'h05AA_0000_0000_0000, 1);
    sendTx(24, 64'h77F0_0F00_0000_0000, 20);

    curReq = "R1 disabled";
    proxyOn = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0, 0);
    sendTx(40, 64'h0312_3456_7800_0000, 10);
    sendTx(24, 64'h0577_0000_0000_0000, 10);
    proxyOn = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 0, 0);
    curReq = "R2 after re-enable";
    sendTx(32, 64'h6601_0203_0000_0000, 20);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired (%s) got hang expected completion", curReq);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule